// File: doc/BRIEF.md
# Tagged Operand-Wait Station

This block buffers operations in front of a single functional unit in a dynamically scheduled pipeline. When an operation is issued, each of its two source operands arrives in one of two forms. It is either a value that is already known, or a pending marker carrying the identifier of the operation that will produce it. The station holds the operation until both operands are known, then hands it to the unit. The issue side does not have to wait for the unit, because the station decouples the two.

Every slot in the station has its own identifier, built from a station number and the slot index. The issue logic is given the identifier of the slot that will receive the next operation, so it can label the destination of that operation with it. The unit later broadcasts its result under that label. Pending operands snoop a single result broadcast bus. Any operand whose awaited identifier matches a valid broadcast takes the value. When several operands are ready, the one issued earliest is dispatched first. A slot becomes free on the cycle it dispatches.

Top module: `rs_station`

## Requirements
- R1: While the synchronous active-high reset `rst` is held, and on the first cycle after it is released, every slot is empty, `full` is low and `dsp_valid` is low.
- R2: An accepted issue goes into the lowest-numbered empty slot. `iss_tag` shows that slot's identifier whenever `full` is low. An identifier is the station number in the upper bits and the slot index in the low log2(entries) bits, so the defaults of station 2 and 4 slots give identifiers 8 to 11.
- R3: An operand issued with its ready flag set keeps the value it came with, and the bus never overwrites it.
- R4: A valid broadcast hands its value, at that clock edge, to every stored pending operand whose awaited identifier equals the broadcast identifier. This covers both operands of every slot.
- R5: A pending operand that is being issued on the same edge as a matching broadcast captures the broadcast value at issue.
- R6: `dsp_valid` is high exactly when some occupied slot has both operands ready. `dsp_op`, `dsp_a`, `dsp_b` and `dsp_tag` then show that slot's opcode, operand values and identifier. They are combinational from stored state, so an operand woken at an edge can dispatch no earlier than the cycle after that edge.
- R7: When more than one slot is ready, the slot that was issued earliest is the one presented, whatever its index.
- R8: A presented slot is released at the next edge, and it can accept a new issue from the edge after that.
- R9: `full` is high exactly when every slot is occupied. An issue request while `full` is high changes nothing.
- R10: A broadcast with `bc_valid` low, or with an identifier that no pending operand awaits, leaves all operands unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| iss_valid | input | 1 | Issue request |
| iss_op | input | OP_W | Opcode of issued operation |
| iss_a_rdy | input | 1 | Operand A is a value (1) or a pending identifier (0) |
| iss_a_tag | input | TAG_W | Producer identifier of operand A when pending |
| iss_a_val | input | DATA_W | Value of operand A when ready |
| iss_b_rdy | input | 1 | Operand B is a value (1) or a pending identifier (0) |
| iss_b_tag | input | TAG_W | Producer identifier of operand B when pending |
| iss_b_val | input | DATA_W | Value of operand B when ready |
| iss_tag | output | TAG_W | Identifier of the slot the next issue will occupy |
| full | output | 1 | All slots occupied; issue must stall |
| bc_valid | input | 1 | Result broadcast valid |
| bc_tag | input | TAG_W | Identifier of the broadcast result |
| bc_val | input | DATA_W | Broadcast result value |
| dsp_valid | output | 1 | A ready operation is presented to the unit |
| dsp_op | output | OP_W | Opcode of presented operation |
| dsp_a | output | DATA_W | Operand A value of presented operation |
| dsp_b | output | DATA_W | Operand B value of presented operation |
| dsp_tag | output | TAG_W | Identifier of presented operation |

## Verification
One sequence fills every slot with operations that all wait on a single identifier, then wakes them with one broadcast. This separates a wakeup that reaches all matches from one that reaches only the first, and it makes the earliest-issued ordering visible. Other directed sequences send a non-matching broadcast against a full station, issue a pending operand on the same edge as its broadcast, and make a younger operation ready before an older one. Each of these pinpoints one failure: a false capture, a lost wakeup, or dispatch by index instead of by age. A long mixed run with slot reuse then places age order and slot index out of step. A behavioural queue model is compared with every output on every cycle.

// File: rtl/rs_pkg.sv
package rs_pkg;
    parameter int ENTRIES = 4;
    parameter int TAG_W = 4;
    parameter int DATA_W = 16;
    parameter int OP_W = 4;
    parameter int STN_ID = 2;
    localparam int IDX_W = $clog2(ENTRIES);
    localparam int STN_W = TAG_W - IDX_W;

    typedef struct packed {
        logic              rdy;
        logic [TAG_W-1:0]  tag;
        logic [DATA_W-1:0] val;
    } opnd_t;

    typedef struct packed {
        logic            busy;
        logic [OP_W-1:0] op;
        opnd_t           a;
        opnd_t           b;
    } slot_t;

    typedef struct packed {
        slot_t [ENTRIES-1:0]               slot;
        // older[i][j] set: slot i was issued before slot j
        logic  [ENTRIES-1:0][ENTRIES-1:0]  older;
    } state_t;

    // Capture a broadcast into a waiting operand on a tag match
    function automatic opnd_t snoop(opnd_t o, logic v, logic [TAG_W-1:0] t,
                                    logic [DATA_W-1:0] d);
        opnd_t r;
        r = o;
        if (!o.rdy && v && (o.tag == t)) begin
            r.rdy = 1'b1;
            r.val = d;
        end
        return r;
    endfunction
endpackage

// File: rtl/rs_free_pick.sv
module rs_free_pick #(
    parameter int N = 4,
    parameter int W = 2
) (
    input  logic [N-1:0] busy,
    output logic         found,
    output logic [W-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!busy[i]) begin
                found = 1'b1;
                idx   = W'(i);
            end
        end
    end
endmodule

// File: rtl/rs_age_pick.sv
module rs_age_pick #(
    parameter int N = 4,
    parameter int W = 2
) (
    input  logic [N-1:0]        ready,
    input  logic [N-1:0][N-1:0] older,
    output logic                found,
    output logic [W-1:0]        idx
);
    logic [N-1:0] win;

    for (genvar g = 0; g < N; g++) begin : g_win
        logic [N-1:0] col;
        for (genvar h = 0; h < N; h++) begin : g_bit
            if (h == g) begin : g_self
                assign col[h] = 1'b0;
            end else begin : g_other
                assign col[h] = older[h][g];
            end
        end
        assign win[g] = ready[g] & ~|(ready & col);
    end

    always_comb begin
        found = |ready;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (win[i]) idx = W'(i);
        end
    end
endmodule

// File: rtl/rs_station.sv
module rs_station
    import rs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              iss_valid,
    input  logic [OP_W-1:0]   iss_op,
    input  logic              iss_a_rdy,
    input  logic [TAG_W-1:0]  iss_a_tag,
    input  logic [DATA_W-1:0] iss_a_val,
    input  logic              iss_b_rdy,
    input  logic [TAG_W-1:0]  iss_b_tag,
    input  logic [DATA_W-1:0] iss_b_val,
    output logic [TAG_W-1:0]  iss_tag,
    output logic              full,
    input  logic              bc_valid,
    input  logic [TAG_W-1:0]  bc_tag,
    input  logic [DATA_W-1:0] bc_val,
    output logic              dsp_valid,
    output logic [OP_W-1:0]   dsp_op,
    output logic [DATA_W-1:0] dsp_a,
    output logic [DATA_W-1:0] dsp_b,
    output logic [TAG_W-1:0]  dsp_tag
);
    localparam logic [STN_W-1:0] STN_BITS = STN_W'(STN_ID);

    state_t st_q, st_d;

    logic [ENTRIES-1:0] busy_q_vec;
    logic [ENTRIES-1:0] ready_q_vec;
    logic               have_free;
    logic [IDX_W-1:0]   free_idx;
    logic               dsp_found;
    logic [IDX_W-1:0]   dsp_idx;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_flags
        assign busy_q_vec[g]  = st_q.slot[g].busy;
        assign ready_q_vec[g] = st_q.slot[g].busy & st_q.slot[g].a.rdy
                              & st_q.slot[g].b.rdy;
    end

    rs_free_pick #(.N(ENTRIES), .W(IDX_W)) u_free (
        .busy  (busy_q_vec),
        .found (have_free),
        .idx   (free_idx)
    );

    rs_age_pick #(.N(ENTRIES), .W(IDX_W)) u_age (
        .ready (ready_q_vec),
        .older (st_q.older),
        .found (dsp_found),
        .idx   (dsp_idx)
    );

    always_comb begin
        st_d = st_q;
        // wakeup of stored operands
        for (int i = 0; i < ENTRIES; i++) begin
            if (st_q.slot[i].busy) begin
                st_d.slot[i].a = snoop(st_q.slot[i].a, bc_valid, bc_tag, bc_val);
                st_d.slot[i].b = snoop(st_q.slot[i].b, bc_valid, bc_tag, bc_val);
            end
        end
        // release on dispatch
        if (dsp_found) begin
            st_d.slot[dsp_idx].busy = 1'b0;
        end
        // accept issue into lowest empty slot, snooping the bus at the same edge
        if (iss_valid && have_free) begin
            st_d.slot[free_idx].busy = 1'b1;
            st_d.slot[free_idx].op   = iss_op;
            st_d.slot[free_idx].a    = snoop({iss_a_rdy, iss_a_tag, iss_a_val},
                                             bc_valid, bc_tag, bc_val);
            st_d.slot[free_idx].b    = snoop({iss_b_rdy, iss_b_tag, iss_b_val},
                                             bc_valid, bc_tag, bc_val);
            for (int j = 0; j < ENTRIES; j++) begin
                st_d.older[j][free_idx] = busy_q_vec[j];
                st_d.older[free_idx][j] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign full      = ~have_free;
    assign iss_tag   = {STN_BITS, free_idx};
    assign dsp_valid = dsp_found;
    assign dsp_op    = st_q.slot[dsp_idx].op;
    assign dsp_a     = st_q.slot[dsp_idx].a.val;
    assign dsp_b     = st_q.slot[dsp_idx].b.val;
    assign dsp_tag   = {STN_BITS, dsp_idx};
endmodule

// File: rtl/rs_station_chk.sv
module rs_station_chk
    import rs_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               iss_valid,
    input logic               full,
    input logic               dsp_valid,
    input logic [ENTRIES-1:0] busy
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!full && !dsp_valid && (busy == '0)));

    // R9
    full_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (full && !dsp_valid) |=> full);

    // R8
    free_after_dispatch_chk: assert property (@(posedge clk) disable iff (rst)
        dsp_valid |=> !full);

    // R2
    issue_grow_chk: assert property (@(posedge clk) disable iff (rst)
        (iss_valid && !full && !dsp_valid)
            |=> ($countones(busy) == $past($countones(busy)) + 1));

    // R10
    idle_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (!iss_valid && !dsp_valid) |=> $stable(busy));
endmodule

bind rs_station rs_station_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .iss_valid (iss_valid),
    .full      (full),
    .dsp_valid (dsp_valid),
    .busy      (busy_q_vec)
);

// File: tb/rs_station_test.sv
`timescale 1ns/1ps
module rs_station_test;
    import rs_pkg::*;

    localparam int N = ENTRIES;

    typedef struct {
        int idx; int op;
        bit ar; int at; int av;
        bit br; int bt; int bv;
    } ment_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic              iss_valid = 1'b0;
    logic [OP_W-1:0]   iss_op = '0;
    logic              iss_a_rdy = 1'b0, iss_b_rdy = 1'b0;
    logic [TAG_W-1:0]  iss_a_tag = '0, iss_b_tag = '0;
    logic [DATA_W-1:0] iss_a_val = '0, iss_b_val = '0;
    logic              bc_valid = 1'b0;
    logic [TAG_W-1:0]  bc_tag = '0;
    logic [DATA_W-1:0] bc_val = '0;
    logic [TAG_W-1:0]  iss_tag, dsp_tag;
    logic              full, dsp_valid;
    logic [OP_W-1:0]   dsp_op;
    logic [DATA_W-1:0] dsp_a, dsp_b;

    int total = 0, bad = 0;
    bit done = 0;
    string phase = "R1";
    ment_t mq[$];
    int tags[4] = '{1, 3, 5, 12};

    always #2 clk = ~clk;

    rs_station uut (
        .clk(clk), .rst(rst),
        .iss_valid(iss_valid), .iss_op(iss_op),
        .iss_a_rdy(iss_a_rdy), .iss_a_tag(iss_a_tag), .iss_a_val(iss_a_val),
        .iss_b_rdy(iss_b_rdy), .iss_b_tag(iss_b_tag), .iss_b_val(iss_b_val),
        .iss_tag(iss_tag), .full(full),
        .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_val(bc_val),
        .dsp_valid(dsp_valid), .dsp_op(dsp_op), .dsp_a(dsp_a), .dsp_b(dsp_b),
        .dsp_tag(dsp_tag)
    );

    task automatic check(string req, int got, int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s phase=%s actual=%0d expected=%0d", req, phase, got, exp);
        end
    endtask

    function automatic int lowest_free();
        for (int i = 0; i < N; i++) begin
            bit used = 0;
            foreach (mq[k]) if (mq[k].idx == i) used = 1;
            if (!used) return i;
        end
        return 0;
    endfunction

    function automatic int first_ready();
        foreach (mq[k]) if (mq[k].ar && mq[k].br) return k;
        return -1;
    endfunction

    task automatic compare();
        int ef = (mq.size() == N) ? 1 : 0;
        int fr = first_ready();
        check("R9", int'(full), ef);
        if (ef == 0) check("R2", int'(iss_tag), (STN_ID << IDX_W) + lowest_free());
        check("R6", int'(dsp_valid), (fr >= 0) ? 1 : 0);
        if (fr >= 0) begin
            check("R7", int'(dsp_tag), (STN_ID << IDX_W) + mq[fr].idx);
            check("R6", int'(dsp_op), mq[fr].op);
            check("R4", int'(dsp_a), mq[fr].av);
            check("R4", int'(dsp_b), mq[fr].bv);
        end
    endtask

    task automatic model_update();
        int n0 = mq.size();
        int fr = first_ready();
        int nf = lowest_free();
        ment_t e;
        if (fr >= 0) mq.delete(fr);
        if (bc_valid) begin
            foreach (mq[k]) begin
                if (!mq[k].ar && mq[k].at == int'(bc_tag)) begin
                    mq[k].ar = 1; mq[k].av = int'(bc_val);
                end
                if (!mq[k].br && mq[k].bt == int'(bc_tag)) begin
                    mq[k].br = 1; mq[k].bv = int'(bc_val);
                end
            end
        end
        if (iss_valid && n0 < N) begin
            e.idx = nf; e.op = int'(iss_op);
            e.ar = iss_a_rdy; e.at = int'(iss_a_tag); e.av = int'(iss_a_val);
            e.br = iss_b_rdy; e.bt = int'(iss_b_tag); e.bv = int'(iss_b_val);
            if (bc_valid && !e.ar && e.at == int'(bc_tag)) begin e.ar = 1; e.av = int'(bc_val); end
            if (bc_valid && !e.br && e.bt == int'(bc_tag)) begin e.br = 1; e.bv = int'(bc_val); end
            mq.push_back(e);
        end
    endtask

    task automatic step(bit iv, bit ar, int at, bit br, int bt, bit cv, int ct);
        @(negedge clk);
        compare();
        iss_valid = iv;
        iss_op    = OP_W'($urandom);
        iss_a_rdy = ar; iss_a_tag = TAG_W'(at); iss_a_val = DATA_W'($urandom);
        iss_b_rdy = br; iss_b_tag = TAG_W'(bt); iss_b_val = DATA_W'($urandom);
        bc_valid  = cv; bc_tag = TAG_W'(ct); bc_val = DATA_W'($urandom);
        @(posedge clk);
        model_update();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", int'(full), 0);
        check("R1", int'(dsp_valid), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1", int'(full), 0);
        check("R1", int'(dsp_valid), 0);

        phase = "R9";   // fill with waiters on tag 1, extra issues ignored
        for (int k = 0; k < 6; k++) step(1, 0, 1, 1, 0, 0, 0);
        phase = "R10";  // non-matching and invalid broadcasts
        step(0, 0, 0, 0, 0, 1, 6);
        step(0, 0, 0, 0, 0, 0, 1);
        phase = "R4";   // one broadcast wakes all four
        step(0, 0, 0, 0, 0, 1, 1);
        for (int k = 0; k < 5; k++) step(0, 0, 0, 0, 0, 0, 0);
        phase = "R5";   // capture at issue on the same edge
        step(1, 0, 3, 0, 5, 1, 3);
        step(0, 0, 0, 0, 0, 1, 5);
        for (int k = 0; k < 3; k++) step(0, 0, 0, 0, 0, 0, 0);
        phase = "R3";   // ready operands keep their values
        step(1, 1, 3, 1, 3, 1, 3);
        step(0, 0, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0, 0);
        phase = "R7";   // younger ready first, then older pair
        step(1, 0, 12, 1, 0, 0, 0);
        step(1, 0, 5, 1, 0, 0, 0);
        step(1, 1, 0, 0, 12, 0, 0);
        step(0, 0, 0, 0, 0, 1, 5);
        step(1, 0, 12, 1, 0, 0, 0);
        step(0, 0, 0, 0, 0, 1, 12);
        for (int k = 0; k < 5; k++) step(0, 0, 0, 0, 0, 0, 0);
        phase = "R8";   // mixed traffic with slot reuse
        for (int k = 0; k < 4000; k++) begin
            int ct = ($urandom % 5 == 4) ? 6 : tags[$urandom % 4];
            step(($urandom % 3) != 0, $urandom % 2, tags[$urandom % 4],
                 $urandom % 2, tags[$urandom % 4], $urandom % 2, ct);
        end
        for (int k = 0; k < 24; k++) step(0, 0, 0, 0, 0, 1, tags[k % 4]);
        @(negedge clk);
        compare();
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R8 watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule